// File: doc/BRIEF.md
# UART Transmit Serializer

This block turns characters into asynchronous serial frames on a single output line. Software programs two registers through a small write port. One is a control word whose enable bits gate the whole transmitter. The other is a line-format word that sets the character width, the parity mode, the stop-bit count and whether characters queue in a 16-entry FIFO or in a single holding slot. Characters enter through a byte write strobe. A baud tick, pulsed at sixteen times the bit rate, sets the pace of every bit on the line.

When the transmitter is enabled and a character is waiting, the block takes the oldest character and latches the current line format with it. It then drives the frame on the line: a low start bit, the data bits starting from the least significant one, an optional parity bit, and one or two high stop bits. Between frames the line rests high. A busy flag covers the whole frame. The FIFO empty, full and level outputs let the producer pace its writes.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset the line is high, busy is low, the FIFO reports empty and not full, the level is 0, and the line stays high whenever busy is low.
- R2: A frame starts only while control bit 0 (global enable) and control bit 8 (transmit enable) are both 1. With either bit at 0, queued characters stay queued and the line stays high. A register write with select 0 loads the control word, and a write with select 1 loads the line-format word.
- R3: A frame is a 0 start bit, then the data bits least significant first, then the stop bits at 1. Every bit lasts exactly 16 baud ticks, however far apart the ticks are.
- R4: Line-format bits [6:5] give the data width minus five (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). Character bits above the width are not sent.
- R5: Line-format bit 1 set inserts a parity bit after the data. Bit 2 set selects even parity, so the ones in data plus parity make an even count. Bit 2 clear selects odd parity, which makes that count odd.
- R6: Line-format bit 3 set sends two stop bits. Clear sends one.
- R7: With line-format bit 4 set, the FIFO holds 16 characters and sends them in write order. Full rises at 16. A write while full is dropped.
- R8: With line-format bit 4 clear, the transmit path holds a single character. Full rises at level 1, and a second write is dropped.
- R9: Clearing transmit enable during a frame lets that frame finish intact. No further frame starts until both enables are set again.
- R10: A character write in the same cycle as a character leaving for the line is accepted. The level is unchanged, and both characters are sent in order.
- R11: Busy stays high through the last stop bit and falls when that bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control word, 1 selects the line-format word |
| regWrData | input | 16 | Register write data |
| byteWrEn | input | 1 | Character write strobe |
| byteWrData | input | 8 | Character to queue |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txOut | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is on the line |
| fifoEmpty | output | 1 | No character waiting |
| fifoFull | output | 1 | Queue at its current capacity |
| fifoLevel | output | 5 | Number of characters waiting |

## Verification
A character write and the removal of the queue head for a new frame can land in the same clock cycle. The bench provokes this with one character already queued and transmission disabled. It writes the enable bits, and on the very next cycle it writes a second character, which meets the cycle in which the first character leaves for the line. The check requires the level to stay at 1 with busy high. Both characters must then arrive on the line intact and in order, and a separate property confirms that the level is unchanged whenever an accepted write meets a removal.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int REG_W     = 16;
  localparam int DATA_W    = 8;
  localparam int MIN_W     = 5;
  localparam int MAX_FRAME = 1 + DATA_W + 1 + 2;

  // control word bit positions
  localparam int CTRL_ON_BIT = 0;
  localparam int CTRL_TX_BIT = 8;

  // line-format word: bits [6:1] are kept, lowest kept bit is bit 1
  localparam int LINE_LO = 1;
  localparam int LINE_HI = 6;

  typedef struct packed {
    logic [1:0] widthCode;
    logic       fifoOn;
    logic       stop2;
    logic       parEven;
    logic       parEn;
  } lineFmt_t;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
  } txStrobe_t;

  function automatic lineFmt_t decodeLine(input logic [LINE_HI-LINE_LO:0] bits);
    lineFmt_t f;
    f.parEn     = bits[0];
    f.parEven   = bits[1];
    f.stop2     = bits[2];
    f.fifoOn    = bits[3];
    f.widthCode = bits[5:4];
    return f;
  endfunction

  function automatic int frameBits(input lineFmt_t f);
    return 1 + MIN_W + int'(f.widthCode) + int'(f.parEn) + (f.stop2 ? 2 : 1);
  endfunction

endpackage

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       byteWrEn,
  input  logic [DATA_W-1:0]          byteWrData,
  input  lineFmt_t                   fmt,
  input  txStrobe_t                  strb,
  input  logic                       busy,
  output logic                       txOut,
  output logic                       fifoEmpty,
  output logic                       fifoFull,
  output logic [$clog2(DEPTH+1)-1:0] fifoLevel
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [PTR_W-1:0]     rdPtr;
  logic [PTR_W-1:0]     wrPtr;
  logic [CNT_W-1:0]     count;
  logic [CNT_W-1:0]     capacity;
  logic                 doPush;
  logic                 doPop;
  logic [MAX_FRAME-1:0] frameNext;
  logic [MAX_FRAME-1:0] frameReg;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // capacity follows the queueing mode
  assign capacity  = fmt.fifoOn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign fifoFull  = (count >= capacity);
  assign fifoEmpty = (count == '0);
  assign fifoLevel = count;
  assign doPush    = byteWrEn & ~fifoFull;
  assign doPop     = strb.loadFrame;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= byteWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // assemble the complete frame from the queue head, ones fill the tail
  always_comb begin
    logic [DATA_W-1:0] head;
    logic              ones;
    int                nData;
    head      = mem[rdPtr];
    ones      = 1'b0;
    nData     = MIN_W + int'(fmt.widthCode);
    frameNext = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nData) begin
        frameNext[1 + i] = head[i];
        ones             = ones ^ head[i];
      end
    end
    if (fmt.parEn) frameNext[1 + nData] = fmt.parEven ? ones : ~ones;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strb.loadFrame) begin
      frameReg <= frameNext;
    end else if (strb.shiftBit) begin
      frameReg <= {1'b1, frameReg[MAX_FRAME-1:1]};
    end
  end

  assign txOut = busy ? frameReg[0] : 1'b1;

endmodule

// File: rtl/utx_control.sv
module utx_control
  import utx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             baudTick,
  input  logic             fifoEmpty,
  output logic             ctrlOn,
  output logic             txOn,
  output lineFmt_t         fmt,
  output txStrobe_t        strb,
  output logic             busy
);

  localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BIT_W  = $clog2(MAX_FRAME + 1);

  typedef enum logic {ST_IDLE, ST_SEND} txState_e;

  txState_e                 state;
  logic [LINE_HI-LINE_LO:0] lineBits;
  logic [TICK_W-1:0]        tickCnt;
  logic [BIT_W-1:0]         bitCnt;
  logic [BIT_W-1:0]         lenReg;
  logic                     gateOn;
  logic                     startNow;
  logic                     bitEnd;
  logic                     lastBit;
  logic                     unusedRegBits;

  assign unusedRegBits = ^{regWrData[REG_W-1:CTRL_TX_BIT+1],
                           regWrData[CTRL_TX_BIT-1:LINE_HI+1]};

  // register bank: only the implemented bits are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOn   <= 1'b0;
      txOn     <= 1'b0;
      lineBits <= '0;
    end else if (regWrEn) begin
      if (regSel) begin
        lineBits <= regWrData[LINE_HI:LINE_LO];
      end else begin
        ctrlOn <= regWrData[CTRL_ON_BIT];
        txOn   <= regWrData[CTRL_TX_BIT];
      end
    end
  end

  assign fmt      = decodeLine(lineBits);
  assign gateOn   = ctrlOn & txOn;
  assign startNow = (state == ST_IDLE) & gateOn & ~fifoEmpty;
  assign bitEnd   = baudTick & (tickCnt == TICK_W'(TICKS_PER_BIT - 1));
  assign lastBit  = (bitCnt == lenReg - BIT_W'(1));

  assign strb.loadFrame = startNow;
  assign strb.shiftBit  = (state == ST_SEND) & bitEnd & ~lastBit;
  assign busy           = (state == ST_SEND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lenReg  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state   <= ST_SEND;
            tickCnt <= '0;
            bitCnt  <= '0;
            lenReg  <= BIT_W'(frameBits(fmt));
          end
        end
        ST_SEND: begin
          // enables are not consulted here: a started frame always completes
          if (baudTick) begin
            if (bitEnd) begin
              tickCnt <= '0;
              if (lastBit) state  <= ST_IDLE;
              else         bitCnt <= bitCnt + BIT_W'(1);
            end else begin
              tickCnt <= tickCnt + TICK_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import utx_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic                       regSel,
  input  logic [REG_W-1:0]           regWrData,
  input  logic                       byteWrEn,
  input  logic [DATA_W-1:0]          byteWrData,
  input  logic                       baudTick,
  output logic                       txOut,
  output logic                       busy,
  output logic                       fifoEmpty,
  output logic                       fifoFull,
  output logic [$clog2(DEPTH+1)-1:0] fifoLevel
);

  lineFmt_t  fmt;
  txStrobe_t strb;
  logic      ctrlOn;
  logic      txOn;
  logic      popNow;

  assign popNow = strb.loadFrame;

  utx_control #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .baudTick (baudTick),
    .fifoEmpty(fifoEmpty),
    .ctrlOn   (ctrlOn),
    .txOn     (txOn),
    .fmt      (fmt),
    .strb     (strb),
    .busy     (busy)
  );

  utx_datapath #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .byteWrEn  (byteWrEn),
    .byteWrData(byteWrData),
    .fmt       (fmt),
    .strb      (strb),
    .busy      (busy),
    .txOut     (txOut),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .fifoLevel (fifoLevel)
  );

endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busy,
  input logic                       txOut,
  input logic                       ctrlOn,
  input logic                       txOn,
  input logic                       fifoOn,
  input logic                       byteWrEn,
  input logic                       fifoFull,
  input logic [$clog2(DEPTH+1)-1:0] fifoLevel,
  input logic                       popNow
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctrlOn && txOn));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txOut);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= ($clog2(DEPTH+1))'(DEPTH));

  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && byteWrEn && !popNow) |=> (fifoLevel == $past(fifoLevel)));

  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoOn && fifoLevel <= 1) |=> (fifoLevel <= 1));

  assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (popNow && byteWrEn && !fifoFull) |=> (fifoLevel == $past(fifoLevel)));

endmodule

bind uart_tx_serializer utx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .txOut    (txOut),
  .ctrlOn   (ctrlOn),
  .txOn     (txOn),
  .fifoOn   (fmt.fifoOn),
  .byteWrEn (byteWrEn),
  .fifoFull (fifoFull),
  .fifoLevel(fifoLevel),
  .popNow   (popNow)
);

// File: tb/sim_uart_tx_serializer.sv
module sim_uart_tx_serializer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic        regSel;
  logic [15:0] regWrData;
  logic        byteWrEn;
  logic [7:0]  byteWrData;
  logic        baudTick;
  logic        txOut;
  logic        busy;
  logic        fifoEmpty;
  logic        fifoFull;
  logic [4:0]  fifoLevel;

  int nChecks = 0;
  int nFails  = 0;
  int tickDiv = 1;
  int tickPh  = 0;

  always #4 clk = ~clk;

  uart_tx_serializer u0 (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .byteWrEn  (byteWrEn),
    .byteWrData(byteWrData),
    .baudTick  (baudTick),
    .txOut     (txOut),
    .busy      (busy),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .fifoLevel (fifoLevel)
  );

  always @(negedge clk) begin
    if (tickDiv <= 1) begin
      baudTick <= 1'b1;
    end else if (tickPh == tickDiv - 1) begin
      tickPh = 0;
      baudTick <= 1'b1;
    end else begin
      tickPh = tickPh + 1;
      baudTick <= 1'b0;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lineWord(input int w, input bit pe, input bit ev,
                                           input bit st2, input bit fifo);
    return 16'(((w - 5) << 5) | (int'(fifo) << 4) | (int'(st2) << 3) |
               (int'(ev) << 2) | (int'(pe) << 1));
  endfunction

  task automatic regWrite(input bit sel, input logic [15:0] data);
    @(negedge clk);
    regWrEn   = 1'b1;
    regSel    = sel;
    regWrData = data;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    byteWrEn   = 1'b1;
    byteWrData = b;
    @(negedge clk);
    byteWrEn   = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baudTick) c++;
    end
  endtask

  // receive one frame and check every bit at its centre
  task automatic recvFrame(input int w, input bit pe, input bit ev, input bit st2,
                           input logic [7:0] exp, input string req, input bit expectIdle);
    int         guard = 0;
    bit         seen  = 0;
    logic [7:0] got   = '0;
    logic [7:0] mask;
    logic       par;
    mask = 8'((1 << w) - 1);
    while (!seen && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (txOut === 1'b0) seen = 1;
    end
    if (!seen) begin
      checkEq(req, "start edge seen", 0, 1);
      return;
    end
    waitTicks(8);
    @(negedge clk);
    checkEq("R3", "start bit level", int'(txOut), 0);
    for (int i = 0; i < w; i++) begin
      waitTicks(16);
      @(negedge clk);
      got[i] = txOut;
    end
    checkEq(req, "data bits", int'(got), int'(exp & mask));
    if (pe) begin
      waitTicks(16);
      @(negedge clk);
      par = ev ? ^(exp & mask) : ~^(exp & mask);
      checkEq("R5", "parity bit", int'(txOut), int'(par));
    end
    for (int s = 0; s < (st2 ? 2 : 1); s++) begin
      waitTicks(16);
      @(negedge clk);
      checkEq(st2 ? "R6" : "R3", "stop bit level", int'(txOut), 1);
    end
    waitTicks(6);
    @(negedge clk);
    checkEq("R11", "busy inside last stop bit", int'(busy), 1);
    if (expectIdle) begin
      waitTicks(4);
      @(negedge clk);
      checkEq("R11", "busy after frame", int'(busy), 0);
      checkEq("R1", "line idle after frame", int'(txOut), 1);
    end
  endtask

  task automatic sendOne(input int w, input bit pe, input bit ev, input bit st2,
                         input logic [7:0] data, input string req);
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(w, pe, ev, st2, 1'b1));
    pushByte(data);
    regWrite(1'b0, 16'h0101);
    recvFrame(w, pe, ev, st2, data, req, 1'b1);
  endtask

  task automatic testReset;
    @(negedge clk);
    checkEq("R1", "reset line", int'(txOut), 1);
    checkEq("R1", "reset busy", int'(busy), 0);
    checkEq("R1", "reset empty", int'(fifoEmpty), 1);
    checkEq("R1", "reset full", int'(fifoFull), 0);
    checkEq("R1", "reset level", int'(fifoLevel), 0);
  endtask

  task automatic testFormats;
    sendOne(8, 1'b0, 1'b0, 1'b0, 8'hA5, "R3");
    sendOne(5, 1'b1, 1'b1, 1'b1, 8'hF3, "R4");
    sendOne(6, 1'b1, 1'b0, 1'b0, 8'h2C, "R5");
    sendOne(7, 1'b1, 1'b1, 1'b0, 8'h35, "R5");
    sendOne(8, 1'b1, 1'b0, 1'b1, 8'h00, "R6");
    sendOne(6, 1'b0, 1'b0, 1'b1, 8'h15, "R4");
  endtask

  task automatic testGate;
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(8, 1'b0, 1'b0, 1'b0, 1'b1));
    pushByte(8'hC7);
    regWrite(1'b0, 16'h0001);
    repeat (60) @(negedge clk);
    checkEq("R2", "busy with global enable only", int'(busy), 0);
    checkEq("R2", "line with global enable only", int'(txOut), 1);
    checkEq("R2", "level with global enable only", int'(fifoLevel), 1);
    regWrite(1'b0, 16'h0100);
    repeat (60) @(negedge clk);
    checkEq("R2", "busy with transmit enable only", int'(busy), 0);
    checkEq("R2", "level with transmit enable only", int'(fifoLevel), 1);
    regWrite(1'b0, 16'h0101);
    recvFrame(8, 1'b0, 1'b0, 1'b0, 8'hC7, "R2", 1'b1);
  endtask

  task automatic testFifoFull;
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(8, 1'b0, 1'b0, 1'b0, 1'b1));
    for (int i = 0; i < 17; i++) begin
      pushByte(8'(i * 13 + 7));
      if (i == 14) checkEq("R7", "full below depth", int'(fifoFull), 0);
      if (i == 15) begin
        checkEq("R7", "full at depth", int'(fifoFull), 1);
        checkEq("R7", "level at depth", int'(fifoLevel), 16);
      end
    end
    checkEq("R7", "level after dropped write", int'(fifoLevel), 16);
    regWrite(1'b0, 16'h0101);
    for (int i = 0; i < 16; i++) begin
      recvFrame(8, 1'b0, 1'b0, 1'b0, 8'(i * 13 + 7), "R7", i == 15);
    end
    checkEq("R7", "empty after draining", int'(fifoEmpty), 1);
    checkEq("R7", "level after draining", int'(fifoLevel), 0);
  endtask

  task automatic testBypass;
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(8, 1'b0, 1'b0, 1'b0, 1'b0));
    pushByte(8'h3C);
    checkEq("R8", "single slot full", int'(fifoFull), 1);
    checkEq("R8", "single slot level", int'(fifoLevel), 1);
    pushByte(8'hC3);
    checkEq("R8", "level after second write", int'(fifoLevel), 1);
    regWrite(1'b0, 16'h0101);
    recvFrame(8, 1'b0, 1'b0, 1'b0, 8'h3C, "R8", 1'b1);
    checkEq("R8", "second write was dropped", int'(fifoEmpty), 1);
  endtask

  task automatic testMidDisable;
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(8, 1'b0, 1'b0, 1'b0, 1'b1));
    pushByte(8'h96);
    pushByte(8'h69);
    regWrite(1'b0, 16'h0101);
    fork
      recvFrame(8, 1'b0, 1'b0, 1'b0, 8'h96, "R9", 1'b1);
      begin
        repeat (50) @(negedge clk);
        regWrite(1'b0, 16'h0000);
      end
    join
    repeat (60) @(negedge clk);
    checkEq("R9", "no new frame while disabled", int'(busy), 0);
    checkEq("R9", "second char still queued", int'(fifoLevel), 1);
    regWrite(1'b0, 16'h0101);
    recvFrame(8, 1'b0, 1'b0, 1'b0, 8'h69, "R9", 1'b1);
  endtask

  task automatic testPushPop;
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, lineWord(8, 1'b0, 1'b0, 1'b0, 1'b1));
    pushByte(8'h11);
    @(negedge clk);
    regWrEn   = 1'b1;
    regSel    = 1'b0;
    regWrData = 16'h0101;
    @(negedge clk);
    regWrEn    = 1'b0;
    byteWrEn   = 1'b1;
    byteWrData = 8'h22;
    @(negedge clk);
    byteWrEn   = 1'b0;
    checkEq("R10", "level after write meets removal", int'(fifoLevel), 1);
    checkEq("R10", "frame started", int'(busy), 1);
    recvFrame(8, 1'b0, 1'b0, 1'b0, 8'h11, "R10", 1'b0);
    recvFrame(8, 1'b0, 1'b0, 1'b0, 8'h22, "R10", 1'b1);
  endtask

  task automatic testSlowTick;
    tickDiv = 3;
    sendOne(8, 1'b0, 1'b0, 1'b0, 8'h5A, "R3");
    tickDiv = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN       = 1'b0;
    regWrEn    = 1'b0;
    regSel     = 1'b0;
    regWrData  = '0;
    byteWrEn   = 1'b0;
    byteWrData = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFormats();
    testGate();
    testFifoFull();
    testBypass();
    testMidDisable();
    testPushPop();
    testSlowTick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule